// File: doc/BRIEF.md
# Stereo DC-Blocking High-Pass Filter

This block strips the DC component from a two-channel stream of 24-bit two's complement audio samples. A strobe marks each sample period, and on that strobe one left and one right sample arrive together. Each channel goes through its own first-order recursive high-pass section. The pole sits at `1 - 2^-K`. With the default `K = 13`, this puts the -3 dB corner just under 1 Hz when the strobe runs at 48 kHz. Because the filter works per sample, the corner follows the sample rate: doubling the strobe rate doubles the corner.

A run-time enable input chooses between the filtered result and a bypass that passes the sample through unchanged. The enable is sampled with each strobe. While the block is in bypass, the recursive state is held at zero and the previous-input register keeps following the stream. Switching the filter back on therefore starts cleanly, with no stored history.

The recursion keeps `FRAC_W` fractional bits and three guard bits above the sample width. The 24-bit result saturates instead of wrapping. Results come out one clock after the strobe, each marked by a one-cycle valid pulse.

Top module: `dcb_stereo`

## Requirements
- R1: After reset, `out_stb` is 0, both outputs are 0, and all filter state is zero. The first filtered sample after reset therefore equals its input sample.
- R2: `out_stb` is high for exactly the one clock cycle after each cycle in which `smp_stb` is high, and low otherwise.
- R3: When `hpf_on` is 1 at a strobe, each channel updates `acc <= acc + ((x - xp) * 2^FRAC_W) - (acc >>> K)` and outputs `floor(acc_new / 2^FRAC_W)`, saturated. Here `acc` is the internal accumulator, `x` the new sample, `xp` the previous sample, and the defaults are K = 13, FRAC_W = 16.
- R4: When `hpf_on` is 0 at a strobe, each output equals that channel's input sample exactly and the accumulator is cleared to zero.
- R5: On the first filtered strobe after a bypassed strobe, each output equals the new input minus the last bypassed input, saturated.
- R6: Filtered results above 8388607 give 0x7FFFFF, and results below -8388608 give 0x800000.
- R7: The left and right channels keep separate state. One channel's inputs never change the other channel's output.
- R8: Input changes in cycles without `smp_stb` have no effect: the outputs hold their values and no state advances.
- R9: A constant filtered input makes the accumulator decay towards zero without increasing. After 30000 samples of a DC level of 1000000, the output is below 40000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| hpf_on | input | 1 | 1 = filter, 0 = bypass; sampled with the strobe |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_stb | output | 1 | One-cycle pulse marking new output samples |
| out_l | output | 24 | Left output sample, two's complement |
| out_r | output | 24 | Right output sample, two's complement |

## Verification
The hardest situation to reach is the end of the slow decay. With a pole this close to one, the output needs tens of thousands of strobes before it falls by a large factor. The stimulus therefore drives a 30000-sample DC run at one strobe every two clocks and checks the final magnitude. Saturation in both directions is reached by first bypassing a full-scale sample of one sign, which leaves the accumulator at zero and the previous input at the extreme. The next sample is then the opposite full-scale value with the filter on, so the step is close to twice the range.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int DCB_CHANNELS = 2;

    typedef enum logic {
        DCB_BYPASS = 1'b0,
        DCB_FILTER = 1'b1
    } dcb_mode_e;

endpackage

// File: rtl/dcb_sat.sv
module dcb_sat #(
    parameter int IN_W  = 27,
    parameter int OUT_W = 24
) (
    input  logic [IN_W-1:0]  v,
    output logic [OUT_W-1:0] o
);
    localparam int HEAD_W = IN_W - OUT_W + 1;

    logic [HEAD_W-1:0] head;
    logic              fits;

    always_comb begin
        head = v[IN_W-1:OUT_W-1];
        fits = (&head) | ~(|head);
        if (fits) begin
            o = v[OUT_W-1:0];
        end else begin
            o = {v[IN_W-1], {(OUT_W-1){~v[IN_W-1]}}};
        end
    end
endmodule

// File: rtl/dcb_chan.sv
module dcb_chan
    import dcb_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHIFT_K = 13,
    parameter int FRAC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  dcb_mode_e         mode,
    input  logic [DATA_W-1:0] x,
    output logic [DATA_W-1:0] y
);
    localparam int GUARD_W = 3;
    localparam int ACC_W   = DATA_W + GUARD_W + FRAC_W;
    localparam int INT_W   = ACC_W - FRAC_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [DATA_W-1:0]       xprev;
        logic [DATA_W-1:0]       y;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic signed [ACC_W-1:0] acc_cur;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] xp_ext;
    logic signed [ACC_W-1:0] step_v;
    logic signed [ACC_W-1:0] leak_v;
    logic signed [ACC_W-1:0] acc_next;
    logic [DATA_W-1:0]       sat_y;

    always_comb begin
        acc_cur  = st_q.acc;
        x_ext    = {{(ACC_W-DATA_W){x[DATA_W-1]}}, x};
        xp_ext   = {{(ACC_W-DATA_W){st_q.xprev[DATA_W-1]}}, st_q.xprev};
        step_v   = (x_ext - xp_ext) <<< FRAC_W;
        leak_v   = acc_cur >>> SHIFT_K;
        acc_next = acc_cur + step_v - leak_v;
    end

    dcb_sat #(
        .IN_W  (INT_W),
        .OUT_W (DATA_W)
    ) u_sat (
        .v (acc_next[ACC_W-1:FRAC_W]),
        .o (sat_y)
    );

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.xprev = x;
            if (mode == DCB_FILTER) begin
                st_d.acc = acc_next;
                st_d.y   = sat_y;
            end else begin
                st_d.acc = '0;
                st_d.y   = x;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y = st_q.y;

    // R8: no strobe, no change
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(y) && $stable(st_q.acc) && $stable(st_q.xprev)));

    // R4: bypass passes the sample and clears the accumulator
    a_r4_bypass_passes_input: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && mode == DCB_BYPASS) |=> ((y == $past(x)) && (st_q.acc == '0)));

    // R9: constant non-negative state under constant input never grows
    a_r9_dc_decays: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && mode == DCB_FILTER && x == st_q.xprev && st_q.acc >= 0)
        |=> (st_q.acc <= $past(st_q.acc) && st_q.acc >= 0));
endmodule

// File: rtl/dcb_stereo.sv
module dcb_stereo
    import dcb_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHIFT_K = 13,
    parameter int FRAC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              hpf_on,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic              out_stb,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);
    logic [DATA_W-1:0] ch_in  [DCB_CHANNELS];
    logic [DATA_W-1:0] ch_out [DCB_CHANNELS];
    dcb_mode_e         mode;
    logic              vld_d, vld_q;

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;
    assign mode     = hpf_on ? DCB_FILTER : DCB_BYPASS;

    for (genvar ch = 0; ch < DCB_CHANNELS; ch++) begin : g_ch
        dcb_chan #(
            .DATA_W  (DATA_W),
            .SHIFT_K (SHIFT_K),
            .FRAC_W  (FRAC_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (smp_stb),
            .mode  (mode),
            .x     (ch_in[ch]),
            .y     (ch_out[ch])
        );
    end

    always_comb begin
        vld_d = smp_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
        end
    end

    assign out_stb = vld_q;
    assign out_l   = ch_out[0];
    assign out_r   = ch_out[1];

    // R2: each strobe yields one valid pulse a cycle later
    a_r2_strobe_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> out_stb);

    // R2: no valid pulse without a strobe
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !out_stb);
endmodule

// File: tb/dcb_stereo_bench.sv
module dcb_stereo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic        hpf_on = 1'b0;
    logic [23:0] in_l = '0;
    logic [23:0] in_r = '0;
    logic        out_stb;
    logic [23:0] out_l;
    logic [23:0] out_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    q_l[$];
    int    q_r[$];
    string q_tag[$];

    longint acc_m[2];
    int     xp_m[2];
    int     last_l = 0;
    int     last_exp_l = 0;
    int     last_exp_r = 0;

    always #4 clk = ~clk;

    dcb_stereo u_dcb_stereo (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_stb (smp_stb),
        .hpf_on  (hpf_on),
        .in_l    (in_l),
        .in_r    (in_r),
        .out_stb (out_stb),
        .out_l   (out_l),
        .out_r   (out_r)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(int ch, int x, bit en);
        longint y;
        if (en) begin
            acc_m[ch] = acc_m[ch] + (longint'(x) - longint'(xp_m[ch])) * 65536
                        - (acc_m[ch] >>> 13);
            y = acc_m[ch] >>> 16;
            if (y > 8388607)  y = 8388607;
            if (y < -8388608) y = -8388608;
        end else begin
            acc_m[ch] = 0;
            y = x;
        end
        xp_m[ch] = x;
        return int'(y);
    endfunction

    task automatic send(int l, int r, bit en, string tag);
        @(negedge clk);
        in_l    = l[23:0];
        in_r    = r[23:0];
        hpf_on  = en;
        smp_stb = 1'b1;
        last_exp_l = model(0, l, en);
        last_exp_r = model(1, r, en);
        q_l.push_back(last_exp_l);
        q_r.push_back(last_exp_r);
        q_tag.push_back(tag);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_stb) begin
            if (q_l.size() == 0) begin
                chk(1'b0, "R2 unexpected out_stb", 1, 0);
            end else begin
                int el, er;
                string tg;
                el = q_l.pop_front();
                er = q_r.pop_front();
                tg = q_tag.pop_front();
                chk(int'($signed(out_l)) == el, {tg, " left"}, int'($signed(out_l)), el);
                chk(int'($signed(out_r)) == er, {tg, " right"}, int'($signed(out_r)), er);
                last_l = int'($signed(out_l));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        acc_m[0] = 0; acc_m[1] = 0; xp_m[0] = 0; xp_m[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(out_stb == 1'b0, "R1 out_stb in reset", int'(out_stb), 0);
        chk(out_l == '0, "R1 out_l in reset", int'(out_l), 0);
        chk(out_r == '0, "R1 out_r in reset", int'(out_r), 0);
        rst_n = 1'b1;

        // R1: first filtered sample equals input
        send(123456, -654321, 1'b1, "R1");

        // R3: filtered random-ish stream
        for (int i = 0; i < 200; i++) begin
            send(int'($urandom % 2000000) - 1000000,
                 int'($urandom % 2000000) - 1000000, 1'b1, "R3");
        end

        // R4: bypass with full-range values
        for (int i = 0; i < 50; i++) begin
            send(int'($urandom % 16777216) - 8388608,
                 int'($urandom % 16777216) - 8388608, 1'b0, "R4");
        end

        // R5: re-enable after bypass, several times
        for (int i = 0; i < 3; i++) begin
            send(40000 * i - 30000, 12345 + i, 1'b0, "R4");
            send(-5000 * i + 777, 90000, 1'b1, "R5");
            send(2000, -2000, 1'b1, "R3");
        end

        // R6: positive and negative saturation
        send(-8388608, 8388607, 1'b0, "R4");
        send(8388607, -8388608, 1'b1, "R6");
        send(8388607, -8388608, 1'b0, "R4");
        send(-8388608, 8388607, 1'b1, "R6");

        // R8: input changes without strobe are ignored
        send(3000, -4000, 1'b1, "R3");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_l   = 24'(i * 99991);
            in_r   = 24'(-i * 7777);
            hpf_on = i[0];
            chk(out_stb == 1'b0, "R8 out_stb idle", int'(out_stb), 0);
            chk(int'($signed(out_l)) == last_exp_l, "R8 out_l hold",
                int'($signed(out_l)), last_exp_l);
            chk(int'($signed(out_r)) == last_exp_r, "R8 out_r hold",
                int'($signed(out_r)), last_exp_r);
        end
        send(3500, -4500, 1'b1, "R8");

        // R7: independent channels, DC left, alternating right
        for (int i = 0; i < 100; i++) begin
            send(700000, (i % 2 == 0) ? 500000 : -500000, 1'b1, "R7");
        end

        // R9: long DC run decays towards zero
        send(0, 0, 1'b0, "R4");
        for (int i = 0; i < 30000; i++) begin
            send(1000000, -1000000, 1'b1, "R9");
        end
        @(negedge clk);
        chk(last_l >= 0 && last_l < 40000, "R9 final magnitude", last_l, 40000);

        repeat (4) @(negedge clk);
        chk(q_l.size() == 0, "R2 pending results", q_l.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule